// File: doc/BRIEF.md
# Serial Single-Multiplier FIR Filter

This block filters a stream of 10-bit two's-complement audio samples with an 8-tap finite impulse response. Only one multiplier and one adder are present. A small controller therefore walks the taps one per clock cycle and feeds each product into a running sum. A new sample is taken on a strobe. Eight cycles of multiply-accumulate follow, and one cycle later the result is presented together with a one-cycle ready pulse for the next stage.

Four coefficient sets live in a computed table, one wide word per set, so a whole set is latched in a single cycle when the sample is accepted. The datapath carries one guard bit, giving 11 bits, so a partial sum may leave the 10-bit range as long as later taps bring it back. Only the final value is cut to 10 bits. A bypass input disables filtering and copies the input straight to the output. A debug port shows either the controller state or the newest stored sample.

Top module: `fir_serial_mac`

## Requirements
- R1: With bypass low, a strobe seen in the idle state at clock edge E0 accepts the sample. The result is y = sum over k=0..7 of term(c[k], x[n-k]), with tap 0 applied to the newest sample. out_ready is high after edge E9 and out_data carries y at that point.
- R2: Each term is computed as follows. Sign-extend both the sample and the coefficient to 11 bits. Multiply them, shift the product arithmetically right by 9 (coefficients are Q1.9), and keep the low 11 bits. The terms are summed in an 11-bit accumulator that wraps, so a partial sum outside the 10-bit range still gives the right final value.
- R3: The output is the low 10 bits of the final 11-bit sum. For example, a sum of 1020 is presented as 10'h3FC.
- R4: The coefficient for set s and tap k is defined as follows. Set 0 is 511 for k<2 and -128 otherwise. Set 1 is 64. Set 2 is +128 for even k and -128 for odd k. Set 3 is 256>>k. The set is taken from set_sel at the accepting edge, and changes to set_sel during a computation have no effect on its result.
- R5: out_ready is a one-cycle pulse per result, and out_data holds its value until the next result.
- R6: Strobes that arrive while a computation is running are ignored. They change neither the current result nor the stored history.
- R7: While bypass is high, a strobe copies smp_data to out_data with out_ready high after the next edge. Bypass also returns the controller to idle, and a bypassed sample is not written into the history.
- R8: Synchronous reset sets the controller to idle and clears the history, the accumulator, out_data, out_ready and dbg_out. A computation cut off by reset produces no result.
- R9: dbg_out is registered. With dbg_sel low it shows {1'b0, state[1:0], tap[2:0]}, where idle=0, run=1 and finish=2. With dbg_sel high it shows bits [9:4] of the newest stored sample while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | Input sample, two's complement |
| set_sel | input | 2 | Coefficient set select |
| bypass | input | 1 | Failsafe copy-through |
| dbg_sel | input | 1 | Debug source select |
| out_data | output | 10 | Filtered or bypassed result |
| out_ready | output | 1 | One-cycle result strobe |
| dbg_out | output | 6 | Debug view |

## Verification
A filtered result is due exactly nine edges after the accepting edge. The bench drives on falling edges and samples at the falling edge after that ninth edge. It also checks that ready is still low one cycle earlier and low again one cycle later. A bypassed result and every debug value are due one edge after their stimulus, and they are sampled at the falling edge that follows it. Expected sums come from a bench model of the stated arithmetic and coefficient formulas.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fir_state_t;

  // Coefficient formula in Q1.9, evaluated at elaboration time.
  function automatic int coef_value(input int set_i, input int tap_i);
    case (set_i)
      0:       return (tap_i < 2) ? 511 : -128;
      1:       return 64;
      2:       return ((tap_i % 2) == 0) ? 128 : -128;
      default: return 256 >> tap_i;
    endcase
  endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
  parameter int TAPS = 8,
  parameter int CW   = 10,
  parameter int SETS = 4,
  localparam int SW  = $clog2(SETS)
) (
  input  logic [SW-1:0]        sel,
  output logic [TAPS*CW-1:0]   word
);

  logic [TAPS*CW-1:0] rom [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign rom[s][k*CW +: CW] = CW'(fir_pkg::coef_value(s, k));
    end
  end

  assign word = rom[sel];

endmodule

// File: rtl/fir_hist.sv
module fir_hist #(
  parameter int DEPTH = 8,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_ofs,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wptr] <= wr_data;
      wptr      <= wptr + 1'b1;
    end
  end

  // offset 0 addresses the newest entry
  assign rd_addr = wptr - AW'(1) - rd_ofs;
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DW   = 10,
  parameter int FRAC = 9,
  localparam int AW  = DW + 1,
  localparam int PW  = 2 * AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] coef,
  output logic [DW-1:0] res
);

  logic signed [AW-1:0] a_ext, c_ext, term, acc;
  logic signed [PW-1:0] prod;

  assign a_ext = {smp[DW-1], smp};
  assign c_ext = {coef[DW-1], coef};
  assign prod  = PW'(a_ext) * PW'(c_ext);
  assign term  = AW'(prod >>> FRAC);

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (step)  acc <= acc + term;
  end

  assign res = acc[DW-1:0];

endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int TAPS = 8,
  localparam int TW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bypass,
  input  logic          smp_valid,
  output logic          accept,
  output logic          step,
  output logic          finish,
  output fir_state_t    state_q,
  output logic [TW-1:0] tap_q
);

  assign accept = (state_q == ST_IDLE) && smp_valid && !bypass;
  assign step   = (state_q == ST_RUN)  && !bypass;
  assign finish = (state_q == ST_DONE) && !bypass;

  always_ff @(posedge clk) begin
    if (rst || bypass) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (smp_valid) begin
          state_q <= ST_RUN;
          tap_q   <= '0;
        end
        ST_RUN: begin
          if (tap_q == TW'(TAPS - 1)) begin
            state_q <= ST_DONE;
            tap_q   <= '0;
          end else begin
            tap_q <= tap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fir_serial_mac.sv
module fir_serial_mac
  import fir_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int DW   = 10,
  parameter int SETS = 4,
  parameter int FRAC = 9,
  parameter int DBGW = 6,
  localparam int SW  = $clog2(SETS),
  localparam int TW  = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_valid,
  input  logic [DW-1:0]   smp_data,
  input  logic [SW-1:0]   set_sel,
  input  logic            bypass,
  input  logic            dbg_sel,
  output logic [DW-1:0]   out_data,
  output logic            out_ready,
  output logic [DBGW-1:0] dbg_out
);

  fir_state_t        state_q;
  logic [TW-1:0]     tap_q;
  logic              accept, step, finish;
  logic [TAPS*DW-1:0] rom_word, coef_q;
  logic [SW-1:0]     set_q;
  logic [DW-1:0]     hist_q, acc_q, coef_cur;

  fir_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .bypass(bypass), .smp_valid(smp_valid),
    .accept(accept), .step(step), .finish(finish),
    .state_q(state_q), .tap_q(tap_q)
  );

  fir_coef_rom #(.TAPS(TAPS), .CW(DW), .SETS(SETS)) u_rom (
    .sel(set_sel), .word(rom_word)
  );

  fir_hist #(.DEPTH(TAPS), .DW(DW)) u_hist (
    .clk(clk), .rst(rst), .wr_en(accept), .wr_data(smp_data),
    .rd_ofs(tap_q), .rd_data(hist_q)
  );

  assign coef_cur = coef_q[tap_q*DW +: DW];

  fir_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst(rst), .clr(accept), .step(step),
    .smp(hist_q), .coef(coef_cur), .res(acc_q)
  );

  // whole coefficient set latched with the sample
  always_ff @(posedge clk) begin
    if (rst) begin
      coef_q <= '0;
      set_q  <= '0;
    end else if (accept) begin
      coef_q <= rom_word;
      set_q  <= set_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_ready <= 1'b0;
      dbg_out   <= '0;
    end else begin
      out_ready <= 1'b0;
      if (bypass) begin
        if (smp_valid) begin
          out_data  <= smp_data;
          out_ready <= 1'b1;
        end
      end else if (finish) begin
        out_data  <= acc_q;
        out_ready <= 1'b1;
      end
      dbg_out <= dbg_sel ? hist_q[DW-1 -: DBGW] : DBGW'({state_q, tap_q});
    end
  end

endmodule

// File: rtl/fir_serial_mac_chk.sv
module fir_serial_mac_chk
  import fir_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int DW   = 10,
  parameter int SETS = 4,
  localparam int SW  = $clog2(SETS),
  localparam int TW  = $clog2(TAPS)
) (
  input logic          clk,
  input logic          rst,
  input logic          bypass,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic [DW-1:0] out_data,
  input logic          out_ready,
  input fir_state_t    state_q,
  input logic [TW-1:0] tap_q,
  input logic [SW-1:0] set_q,
  input logic [DW-1:0] acc_q,
  input logic          hist_wr
);

  assert_last_tap_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && tap_q == TW'(TAPS - 1) && !bypass) |=> (state_q == ST_DONE));

  assert_trunc_out_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && !bypass) |=> (out_ready && out_data == $past(acc_q)));

  assert_set_held_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && !bypass) |=> $stable(set_q));

  assert_busy_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> !hist_wr);

  assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (bypass && smp_valid) |=> (out_ready && out_data == $past(smp_data)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && !out_ready && out_data == '0));

endmodule

bind fir_serial_mac fir_serial_mac_chk #(.TAPS(TAPS), .DW(DW), .SETS(SETS)) u_chk (
  .clk(clk), .rst(rst), .bypass(bypass), .smp_valid(smp_valid),
  .smp_data(smp_data), .out_data(out_data), .out_ready(out_ready),
  .state_q(state_q), .tap_q(tap_q), .set_q(set_q), .acc_q(acc_q),
  .hist_wr(accept)
);

// File: tb/fir_serial_mac_bench.sv
module fir_serial_mac_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic [1:0] set_sel = '0;
  logic       bypass = 1'b0;
  logic       dbg_sel = 1'b0;
  logic [9:0] out_data;
  logic       out_ready;
  logic [5:0] dbg_out;

  int checks = 0;
  int errors = 0;

  logic signed [9:0] hm [8];

  always #5 clk = ~clk;

  fir_serial_mac u_fir_serial_mac (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .set_sel(set_sel), .bypass(bypass), .dbg_sel(dbg_sel),
    .out_data(out_data), .out_ready(out_ready), .dbg_out(dbg_out)
  );

  // stimulus vectors {set, sample}
  localparam logic [11:0] VEC [10] = '{
    {2'd1, 10'h1FF}, {2'd1, 10'h200}, {2'd2, 10'h0C3}, {2'd3, 10'h3F0},
    {2'd0, 10'h155}, {2'd2, 10'h2AA}, {2'd3, 10'h07F}, {2'd1, 10'h001},
    {2'd0, 10'h380}, {2'd3, 10'h1C7}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bcoef(input int s, input int k);
    if (s == 0) return (k < 2) ? 511 : -128;
    if (s == 1) return 64;
    if (s == 2) return (k % 2 == 0) ? 128 : -128;
    return 256 >> k;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) hm[i] = '0;
  endtask

  task automatic model_push(input logic [9:0] x);
    for (int i = 7; i > 0; i--) hm[i] = hm[i-1];
    hm[0] = x;
  endtask

  function automatic logic [9:0] model_eval(input int s);
    logic signed [10:0] acc, a, c;
    logic signed [21:0] p, ps;
    acc = '0;
    for (int k = 0; k < 8; k++) begin
      a   = 11'(hm[k]);
      c   = 11'(bcoef(s, k));
      p   = 22'(a) * 22'(c);
      ps  = p >>> 9;
      acc = acc + ps[10:0];
    end
    return acc[9:0];
  endfunction

  // accept at edge E0, result due after E9; optional disturbance mid-run
  task automatic feed(input logic [1:0] s, input logic [9:0] x, input bit disturb,
                      input string tag);
    logic [9:0] exp;
    @(negedge clk); smp_valid = 1'b1; smp_data = x; set_sel = s;
    @(negedge clk); smp_valid = 1'b0;
    model_push(x);
    exp = model_eval(s);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (disturb && i == 2) begin
        smp_valid = 1'b1; smp_data = 10'h155; set_sel = s ^ 2'd3;
      end else if (disturb && i == 3) begin
        smp_valid = 1'b0;
      end
    end
    chk({tag, " R5 ready low before due"}, 16'(out_ready), 16'd0);
    @(negedge clk);
    chk({tag, " R1 ready due"}, 16'(out_ready), 16'd1);
    chk({tag, " R1 result"}, 16'(out_data), 16'(exp));
    @(negedge clk);
    chk({tag, " R5 single pulse"}, 16'(out_ready), 16'd0);
    chk({tag, " R5 data held"}, 16'(out_data), 16'(exp));
    set_sel = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R8 reset ready", 16'(out_ready), 16'd0);
    chk("R8 reset data", 16'(out_data), 16'd0);
    chk("R9 reset dbg", 16'(dbg_out), 16'd0);

    // table walk: R1 R2 R4
    for (int v = 0; v < 10; v++)
      feed(VEC[v][11:10], VEC[v][9:0], 1'b0, "vec");

    // guard bit and final truncation: R2 R3
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_clear();
    feed(2'd0, 10'h1FF, 1'b0, "R2 first");
    feed(2'd0, 10'h1FF, 1'b0, "R3 sum 1020 wraps");
    chk("R3 value 3FC", 16'(out_data), 16'h3FC);
    for (int i = 0; i < 6; i++) feed(2'd0, 10'h1FF, 1'b0, "R2 guard");
    chk("R2 guard result 252", 16'(out_data), 16'd252);

    // strobe and set change mid-run ignored: R4 R6
    feed(2'd2, 10'h0F0, 1'b1, "R6 R4 disturbed");
    feed(2'd1, 10'h040, 1'b0, "R6 history untouched");

    // debug state view: R9
    dbg_sel = 1'b0;
    @(negedge clk); smp_valid = 1'b1; smp_data = 10'h2C4; set_sel = 2'd3;
    @(negedge clk); smp_valid = 1'b0; model_push(10'h2C4);
    @(negedge clk); chk("R9 dbg run tap0", 16'(dbg_out), 16'd8);
    @(negedge clk); chk("R9 dbg run tap1", 16'(dbg_out), 16'd9);
    repeat (8) @(negedge clk);
    dbg_sel = 1'b1;
    @(negedge clk); chk("R9 dbg newest sample", 16'(dbg_out), 16'(10'h2C4 >> 4));
    dbg_sel = 1'b0;

    // bypass copy: R7
    @(negedge clk); bypass = 1'b1; smp_valid = 1'b1; smp_data = 10'h2A5;
    @(negedge clk); smp_valid = 1'b0;
    chk("R7 bypass ready", 16'(out_ready), 16'd1);
    chk("R7 bypass data", 16'(out_data), 16'h2A5);
    @(negedge clk);
    chk("R7 bypass pulse ends", 16'(out_ready), 16'd0);
    bypass = 1'b0;
    feed(2'd2, 10'h011, 1'b0, "R7 bypass not stored");

    // reset mid-run: R8
    @(negedge clk); smp_valid = 1'b1; smp_data = 10'h1AB; set_sel = 2'd1;
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 mid-run ready", 16'(out_ready), 16'd0);
    chk("R8 mid-run data", 16'(out_data), 16'd0);
    chk("R8 mid-run dbg", 16'(dbg_out), 16'd0);
    model_clear();
    feed(2'd1, 10'h100, 1'b0, "R8 cleared history");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule